// File: doc/BRIEF.md
# Guarded Privileged Region-Base Register

This block holds a single 64-bit privileged configuration word: an enable flag in bit 0 and the start address of a memory region, aligned to 64 KiB, in the upper bits. Software reaches the word only through a guarded access port. Each request carries the requester's privilege level (0 to 3) and a set of control inputs:

- whether the feature exists;
- the security state;
- whether levels 2 and 3 are present or enabled;
- the hypervisor trap enable;
- the fine-grained read and write trap bits and their permission;
- the top-level trap enable and its two "undefined instead" conditions.

The block resolves the request in a fixed priority order into one of four outcomes: completed, undefined, trapped to level 2, or trapped to level 3. One cycle after the request it reports that outcome on one-hot registered flags, together with an exception class. A write that completes updates the stored word. On that write, the block forces reserved bits to zero, and it also zeroes address bits above the configured physical address width. Any other outcome leaves the word untouched. The stored word is always visible on `cfg_value` for the region-matching logic that uses it.

Top module: `priv_reg_guard`

## Requirements
- R1: When either feature-present input is low, or when the request level is 0, the outcome is undefined.
- R2: At level 1 the first matching rule wins. (a) Undefined when level 3 is present, the undefined-first condition holds and the top trap enable is set. (b) Undefined when level 3 is present and nonsecure is 0. (c) Trap to level 2 when level 2 is enabled and the hypervisor trap enable is set. (d) The fine-grained rule of R3. (e) When level 3 is present and its trap enable is set: undefined if the top undefined condition holds, otherwise trap to level 3. (f) Otherwise the access completes.
- R3: The fine-grained rule traps to level 2 only when level 2 is enabled, fine-grained trapping is implemented, and either level 3 is absent or its fine-grained permission bit is 1. It then uses the read trap bit for reads and the write trap bit for writes.
- R4: At level 2 the first matching rule wins. (a) Undefined when level 3 is present and nonsecure is 0. (b) Undefined when level 3 is present with the undefined-first condition and the top trap enable set. (c) Trap to level 3, or undefined when the top undefined condition holds, when level 3 is present and the top trap enable is set. (d) Otherwise complete. The hypervisor and fine-grained bits have no effect.
- R5: At level 3 the access is undefined when nonsecure is 0 and completes otherwise; all trap bits have no effect.
- R6: `rsp_class` is 0x18 on either trap outcome and 0 on completed or undefined outcomes.
- R7: Each request yields exactly one response cycle, one clock later. In that cycle exactly one of `rsp_ok`, `rsp_undef`, `rsp_trap2`, `rsp_trap3` is high. All four are low outside response cycles.
- R8: A completed write changes `cfg_value` at the same clock edge that produces its response. A write with any other outcome, and any read, leaves `cfg_value` unchanged.
- R9: Stored bits 15:1 and bits at or above PA_BITS (48 by default) are always zero. Bit 0 and bits PA_BITS-1:16 keep written data.
- R10: A completed read returns the stored word on `rsp_rdata`. A faulting read and any write return zero.
- R11: After reset `cfg_value` is zero and no response is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Requester privilege level |
| req_wdata | input | 64 | Write data |
| has_region_feat | input | 1 | Region feature implemented |
| has_64bit_state | input | 1 | 64-bit execution state implemented |
| lvl3_present | input | 1 | Level 3 exists |
| lvl2_enabled | input | 1 | Level 2 enabled for this requester |
| nonsecure | input | 1 | Non-secure state bit |
| hyp_trap_en | input | 1 | Hypervisor trap enable |
| fg_trap_impl | input | 1 | Fine-grained trapping implemented |
| fg_trap_allow | input | 1 | Level-3 permission for fine-grained trapping |
| fg_read_trap | input | 1 | Fine-grained trap bit for reads |
| fg_write_trap | input | 1 | Fine-grained trap bit for writes |
| top_trap_en | input | 1 | Level-3 trap enable |
| top_undef_first | input | 1 | Undefined-first condition of level 3 |
| top_undef | input | 1 | Level-3 trap becomes undefined |
| rsp_valid | output | 1 | Response cycle |
| rsp_ok | output | 1 | Access completed |
| rsp_undef | output | 1 | Access undefined |
| rsp_trap2 | output | 1 | Trapped to level 2 |
| rsp_trap3 | output | 1 | Trapped to level 3 |
| rsp_class | output | 6 | Exception class |
| rsp_rdata | output | 64 | Read data |
| cfg_value | output | 64 | Stored register word |

## Verification
The vector table pairs each priority rule with the rule just below it. Each pair sets both conditions at once and then drops the stronger one, so a swapped order shows up as a wrong outcome. Fine-grained vectors flip the read and write bits against the access direction, and they flip the implemented and permission bits against level-3 presence. This separates a crossed read/write select from a wrong permission term. Every vector also writes a fresh data pattern, so the stored word shows whether a faulting write leaked through. An all-ones write then exposes the reserved and above-width masking.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    OUT_OK    = 2'd0,
    OUT_UNDEF = 2'd1,
    OUT_TRAP2 = 2'd2,
    OUT_TRAP3 = 2'd3
  } outcome_t;

  localparam int CLASS_W = 6;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

  typedef struct packed {
    logic feat_ok;
    logic lvl3_present;
    logic lvl2_enabled;
    logic nonsecure;
    logic hyp_trap_en;
    logic fg_impl;
    logic fg_allow;
    logic fg_rd;
    logic fg_wr;
    logic top_trap_en;
    logic top_undef_first;
    logic top_undef;
  } guard_ctrl_t;

endpackage

// File: rtl/guard_decide.sv
module guard_decide
  import guard_pkg::*;
(
  input  guard_ctrl_t ctrl,
  input  logic [1:0]  level,
  input  logic        is_write,
  output outcome_t    outcome
);

  logic     fg_hit;
  logic     top_first_undef;
  outcome_t top_fault;

  always_comb begin
    fg_hit = ctrl.lvl2_enabled && ctrl.fg_impl &&
             (!ctrl.lvl3_present || ctrl.fg_allow) &&
             (is_write ? ctrl.fg_wr : ctrl.fg_rd);
    top_first_undef = ctrl.lvl3_present && ctrl.top_undef_first && ctrl.top_trap_en;
    top_fault = ctrl.top_undef ? OUT_UNDEF : OUT_TRAP3;
  end

  always_comb begin
    outcome = OUT_UNDEF;
    if (!ctrl.feat_ok) begin
      outcome = OUT_UNDEF;
    end else begin
      unique case (level)
        2'd0: outcome = OUT_UNDEF;
        2'd1: begin
          if (top_first_undef)                             outcome = OUT_UNDEF;
          else if (ctrl.lvl3_present && !ctrl.nonsecure)   outcome = OUT_UNDEF;
          else if (ctrl.lvl2_enabled && ctrl.hyp_trap_en)  outcome = OUT_TRAP2;
          else if (fg_hit)                                 outcome = OUT_TRAP2;
          else if (ctrl.lvl3_present && ctrl.top_trap_en)  outcome = top_fault;
          else                                             outcome = OUT_OK;
        end
        2'd2: begin
          if (ctrl.lvl3_present && !ctrl.nonsecure)        outcome = OUT_UNDEF;
          else if (top_first_undef)                        outcome = OUT_UNDEF;
          else if (ctrl.lvl3_present && ctrl.top_trap_en)  outcome = top_fault;
          else                                             outcome = OUT_OK;
        end
        default: outcome = ctrl.nonsecure ? OUT_OK : OUT_UNDEF;
      endcase
    end
  end

endmodule

// File: rtl/guard_cfg_reg.sv
module guard_cfg_reg #(
  parameter int DATA_W  = 64,
  parameter int PA_BITS = 48,
  parameter int ALIGN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value
);

  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] value_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_keep
    if (b == 0) begin : g_flag
      assign keep[b] = 1'b1;
    end else if (b >= ALIGN_W && b < PA_BITS) begin : g_addr
      assign keep[b] = 1'b1;
    end else begin : g_resv
      assign keep[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
    end else if (we) begin
      value_q <= wdata & keep;
    end
  end

  assign value = value_q;

endmodule

// File: rtl/guard_resp.sv
module guard_resp
  import guard_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic               is_write,
  input  outcome_t           outcome,
  input  logic [DATA_W-1:0]  stored,
  output logic               rsp_valid,
  output logic               rsp_ok,
  output logic               rsp_undef,
  output logic               rsp_trap2,
  output logic               rsp_trap3,
  output logic [CLASS_W-1:0] rsp_class,
  output logic [DATA_W-1:0]  rsp_rdata
);

  logic is_trap;

  assign is_trap = (outcome == OUT_TRAP2) || (outcome == OUT_TRAP3);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_undef <= 1'b0;
      rsp_trap2 <= 1'b0;
      rsp_trap3 <= 1'b0;
      rsp_class <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire;
      rsp_ok    <= fire && (outcome == OUT_OK);
      rsp_undef <= fire && (outcome == OUT_UNDEF);
      rsp_trap2 <= fire && (outcome == OUT_TRAP2);
      rsp_trap3 <= fire && (outcome == OUT_TRAP3);
      rsp_class <= (fire && is_trap) ? TRAP_CLASS : '0;
      rsp_rdata <= (fire && !is_write && outcome == OUT_OK) ? stored : '0;
    end
  end

endmodule

// File: rtl/priv_reg_guard.sv
module priv_reg_guard
  import guard_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int PA_BITS = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_level,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              has_region_feat,
  input  logic              has_64bit_state,
  input  logic              lvl3_present,
  input  logic              lvl2_enabled,
  input  logic              nonsecure,
  input  logic              hyp_trap_en,
  input  logic              fg_trap_impl,
  input  logic              fg_trap_allow,
  input  logic              fg_read_trap,
  input  logic              fg_write_trap,
  input  logic              top_trap_en,
  input  logic              top_undef_first,
  input  logic              top_undef,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_undef,
  output logic              rsp_trap2,
  output logic              rsp_trap3,
  output logic [5:0]        rsp_class,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] cfg_value
);

  guard_ctrl_t ctrl;
  outcome_t    outcome;
  logic        wr_en;

  always_comb begin
    ctrl.feat_ok         = has_region_feat && has_64bit_state;
    ctrl.lvl3_present    = lvl3_present;
    ctrl.lvl2_enabled    = lvl2_enabled;
    ctrl.nonsecure       = nonsecure;
    ctrl.hyp_trap_en     = hyp_trap_en;
    ctrl.fg_impl         = fg_trap_impl;
    ctrl.fg_allow        = fg_trap_allow;
    ctrl.fg_rd           = fg_read_trap;
    ctrl.fg_wr           = fg_write_trap;
    ctrl.top_trap_en     = top_trap_en;
    ctrl.top_undef_first = top_undef_first;
    ctrl.top_undef       = top_undef;
  end

  guard_decide u_decide (
    .ctrl     (ctrl),
    .level    (req_level),
    .is_write (req_write),
    .outcome  (outcome)
  );

  assign wr_en = req_valid && req_write && (outcome == OUT_OK);

  guard_cfg_reg #(
    .DATA_W  (DATA_W),
    .PA_BITS (PA_BITS)
  ) u_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .wdata (req_wdata),
    .value (cfg_value)
  );

  guard_resp #(
    .DATA_W (DATA_W)
  ) u_resp (
    .clk       (clk),
    .rst       (rst),
    .fire      (req_valid),
    .is_write  (req_write),
    .outcome   (outcome),
    .stored    (cfg_value),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_undef (rsp_undef),
    .rsp_trap2 (rsp_trap2),
    .rsp_trap3 (rsp_trap3),
    .rsp_class (rsp_class),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int DATA_W  = 64,
  parameter int PA_BITS = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_level,
  input logic              has_region_feat,
  input logic              has_64bit_state,
  input logic              nonsecure,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_undef,
  input logic              rsp_trap2,
  input logic              rsp_trap3,
  input logic [5:0]        rsp_class,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W-1:0] cfg_value
);

  localparam logic [DATA_W-1:0] RESV_MASK =
    ~((((DATA_W)'(1) << PA_BITS) - (DATA_W)'(1)) & ~((DATA_W)'(16'hFFFF))) & ~(DATA_W)'(1);

  logic [3:0] flags;
  assign flags = {rsp_ok, rsp_undef, rsp_trap2, rsp_trap3};

  assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones(flags) == 1);

  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> flags == 4'b0000);

  assert_follow_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_trap_class_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_trap2 || rsp_trap3) |-> rsp_class == 6'h18);

  assert_plain_class_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_ok || rsp_undef) |-> rsp_class == 6'h00);

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (!rsp_ok || !$past(req_write))) |-> $stable(cfg_value));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_value & RESV_MASK) == '0);

  assert_fault_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> rsp_rdata == '0);

  assert_level0_R1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_level) == 2'd0) |-> rsp_undef);

  assert_level3_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_level) == 2'd3 && $past(has_region_feat) &&
     $past(has_64bit_state) && $past(nonsecure)) |-> rsp_ok);

endmodule

bind priv_reg_guard guard_checker #(
  .DATA_W  (DATA_W),
  .PA_BITS (PA_BITS)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .req_level       (req_level),
  .has_region_feat (has_region_feat),
  .has_64bit_state (has_64bit_state),
  .nonsecure       (nonsecure),
  .rsp_valid       (rsp_valid),
  .rsp_ok          (rsp_ok),
  .rsp_undef       (rsp_undef),
  .rsp_trap2       (rsp_trap2),
  .rsp_trap3       (rsp_trap3),
  .rsp_class       (rsp_class),
  .rsp_rdata       (rsp_rdata),
  .cfg_value       (cfg_value)
);

// File: tb/sim_priv_reg_guard.sv
module sim_priv_reg_guard;

  localparam int PA = 48;
  localparam int NV = 24;

  // {wr, level[1:0], feat, l3p, l2e, ns, hyp, fgi, fgallow, fgr, fgw, l3trap, undef_first, undef, expect[1:0]}
  // expect: 0 ok, 1 undefined, 2 trap level 2, 3 trap level 3
  localparam logic [16:0] VEC [NV] = '{
    17'b0_00_1111_0000_0000_01,  // R1 level 0
    17'b1_11_0111_0000_0000_01,  // R1 feature absent
    17'b0_01_1110_0000_0110_01,  // R2 undef-first beats ns
    17'b0_01_1110_1000_0000_01,  // R2 ns beats hyp
    17'b0_01_1111_1000_0100_10,  // R2 hyp beats top trap
    17'b1_01_1101_1000_0000_00,  // R2 hyp without level 2
    17'b0_01_1111_0111_0000_10,  // R3 read uses read bit
    17'b1_01_1111_0111_0000_00,  // R3 write ignores read bit
    17'b1_01_1111_0110_1000_10,  // R3 write uses write bit
    17'b0_01_1111_0101_0000_00,  // R3 not permitted
    17'b0_01_1010_0101_0000_10,  // R3 permitted, level 3 absent
    17'b0_01_1111_0011_1000_00,  // R3 not implemented
    17'b0_01_1111_0000_0100_11,  // R2 trap level 3
    17'b0_01_1111_0000_0101_01,  // R2 top trap undefined
    17'b1_01_1011_0000_0100_00,  // R2 top trap, level 3 absent
    17'b0_10_1110_1000_0000_01,  // R4 ns
    17'b1_10_1111_1111_1000_00,  // R4 hyp and fine-grained ignored
    17'b0_10_1111_0000_0110_01,  // R4 undef-first
    17'b1_10_1111_0000_0100_11,  // R4 trap level 3
    17'b0_10_1111_0000_0101_01,  // R4 top trap undefined
    17'b0_10_1010_0000_0000_00,  // R4 level 3 absent
    17'b1_11_1100_0000_0000_01,  // R5 ns 0
    17'b0_11_1101_0000_0000_00,  // R5 read ok
    17'b1_11_1101_1111_1111_00   // R5 traps ignored
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_level = 2'd0;
  logic [63:0] req_wdata = '0;
  logic        has_region_feat = 1'b0, has_64bit_state = 1'b0;
  logic        lvl3_present = 1'b0, lvl2_enabled = 1'b0, nonsecure = 1'b0;
  logic        hyp_trap_en = 1'b0, fg_trap_impl = 1'b0, fg_trap_allow = 1'b0;
  logic        fg_read_trap = 1'b0, fg_write_trap = 1'b0;
  logic        top_trap_en = 1'b0, top_undef_first = 1'b0, top_undef = 1'b0;
  logic        rsp_valid, rsp_ok, rsp_undef, rsp_trap2, rsp_trap3;
  logic [5:0]  rsp_class;
  logic [63:0] rsp_rdata, cfg_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] model = '0;

  always #10 clk = ~clk;

  priv_reg_guard #(.DATA_W(64), .PA_BITS(PA)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_level(req_level), .req_wdata(req_wdata),
    .has_region_feat(has_region_feat), .has_64bit_state(has_64bit_state),
    .lvl3_present(lvl3_present), .lvl2_enabled(lvl2_enabled), .nonsecure(nonsecure),
    .hyp_trap_en(hyp_trap_en), .fg_trap_impl(fg_trap_impl), .fg_trap_allow(fg_trap_allow),
    .fg_read_trap(fg_read_trap), .fg_write_trap(fg_write_trap),
    .top_trap_en(top_trap_en), .top_undef_first(top_undef_first), .top_undef(top_undef),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_undef(rsp_undef),
    .rsp_trap2(rsp_trap2), .rsp_trap3(rsp_trap3), .rsp_class(rsp_class),
    .rsp_rdata(rsp_rdata), .cfg_value(cfg_value)
  );

  function automatic logic [63:0] keep_mask();
    logic [63:0] m = '0;
    for (int b = 0; b < 64; b++) m[b] = (b == 0) || (b >= 16 && b < PA);
    return m;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] lvl, input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_level = lvl; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_ctrl(input logic [16:0] v);
    has_region_feat = v[13]; lvl3_present = v[12]; lvl2_enabled = v[11];
    nonsecure = v[10]; hyp_trap_en = v[9]; fg_trap_impl = v[8];
    fg_trap_allow = v[7]; fg_read_trap = v[6]; fg_write_trap = v[5];
    top_trap_en = v[4]; top_undef_first = v[3]; top_undef = v[2];
  endtask

  function automatic string lvl_tag(input logic [1:0] l);
    case (l)
      2'd0: return "R1";
      2'd1: return "R2/R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset cfg_value", cfg_value, 64'd0);
    check("R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    rst = 1'b0;
    has_64bit_state = 1'b1;

    // All-ones write at level 3, non-secure: reserved and above-width bits drop
    set_ctrl(17'b0_00_1101_0000_0000_00);
    access(1'b1, 2'd3, '1);
    model = keep_mask();
    check("R9 masked write", cfg_value, model);
    check("R10 write returns zero", rsp_rdata, 64'd0);
    access(1'b0, 2'd3, '0);
    check("R10 read back", rsp_rdata, model);
    @(negedge clk);
    check("R7 idle no response", {60'd0, rsp_valid, rsp_ok, rsp_undef, rsp_trap2}, 64'd0);

    // Second feature flag absent
    has_64bit_state = 1'b0;
    access(1'b1, 2'd1, 64'h0123_4567_89AB_0001);
    check("R1 64-bit state absent undef", {63'd0, rsp_undef}, 64'd1);
    check("R8 undefined write holds", cfg_value, model);
    has_64bit_state = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      logic [63:0] wd;
      logic [3:0]  exp_flags;
      string       t;
      v  = VEC[i];
      wd = ~(64'(i + 1) * 64'h9E37_79B9_7F4A_7C15);
      t  = lvl_tag(v[15:14]);
      set_ctrl(v);
      access(v[16], v[15:14], wd);
      case (v[1:0])
        2'd0: exp_flags = 4'b1000;
        2'd1: exp_flags = 4'b0100;
        2'd2: exp_flags = 4'b0010;
        default: exp_flags = 4'b0001;
      endcase
      check($sformatf("%s R7 outcome vec %0d", t, i),
            {59'd0, rsp_valid, rsp_ok, rsp_undef, rsp_trap2, rsp_trap3}, {59'd0, 1'b1, exp_flags});
      check($sformatf("R6 class vec %0d", i), {58'd0, rsp_class},
            (v[1:0] >= 2'd2) ? 64'h18 : 64'h0);
      if (v[16] && v[1:0] == 2'd0) model = wd & keep_mask();
      check($sformatf("R8 R9 stored vec %0d", i), cfg_value, model);
      check($sformatf("R10 rdata vec %0d", i), rsp_rdata,
            (!v[16] && v[1:0] == 2'd0) ? model : 64'd0);
    end

    // Reset clears a nonzero word
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears word", cfg_value, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule